// File: doc/BRIEF.md
# Streaming Packet Source with Backpressure

This block sits at the output of a pipelined datapath and presents its results to a downstream streaming sink that uses valid, ready, start-of-packet and end-of-packet. Each word the datapath delivers comes with a one-based position number inside its packet. The block marks the first and last word of each packet from that number, stores the word together with those marks in a small FIFO, and offers the FIFO head to the sink.

When the sink stops taking words, the block drops the datapath enable in the same cycle and raises a stall indication. Words the datapath has already started still arrive during the pipeline latency after the enable drops, and the FIFO absorbs them. The block keeps a credit count of those in-flight words, so the enable also stays low whenever one more word could overflow the FIFO. When the sink is ready again and space exists, the enable comes back in that same cycle.

Top module: `strm_pkt_source`

## Requirements
- R1: A word that arrives with `in_valid` high and `in_count` equal to 1 leaves on the output with `out_sop` high (packet size above 1).
- R2: A word that arrives with `in_count` equal to `PKT_LEN` leaves with `out_eop` high (packet size above 1).
- R3: A word whose count lies strictly between 1 and `PKT_LEN` leaves with both `out_sop` and `out_eop` low.
- R4: With `PKT_LEN` equal to 1, every output word has both `out_sop` and `out_eop` high, whatever value `in_count` carries.
- R5: In any cycle where `out_ready` is low, `dp_enable` is low and `stall` is high in that same cycle.
- R6: In a cycle where `out_ready` is high and rst is low, `dp_enable` is high exactly when the number of committed words (held in the FIFO plus enabled but not yet arrived) minus the word being popped is below `DEPTH` = `PIPE_LAT` + 1.
- R7: Words leave in the order they were enabled, none is lost or duplicated across stalls, and the committed words never exceed `DEPTH`.
- R8: While `out_valid` is high and `out_ready` is low, the output word and its marks stay unchanged on the next cycle.
- R9: Synchronous active-high `rst` empties the FIFO: `out_valid` is low during and right after reset. `dp_enable` is low while rst is high and comes back high in the first cycle after release when `out_ready` is high.
- R10: A word arriving into an empty FIFO appears on the output one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Datapath word valid |
| in_data | input | DATA_W | Datapath word |
| in_count | input | $clog2(PKT_LEN+1) | One-based position of the word in its packet |
| dp_enable | output | 1 | Enable toward the datapath pipeline |
| stall | output | 1 | High while the sink refuses words |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the output word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
A wrong credit count appears at the ports as `dp_enable` disagreeing, in the very same cycle, with the bench's count of words produced minus words taken. A count that runs too high shows up as lost throughput, and one that runs too low later shows up as a lost or duplicated word in the output sequence. A corrupted FIFO pointer or framing mark shows on the first transfer that reads the affected slot, as a wrong data value or a misplaced packet mark. A word that changes under backpressure is caught one cycle after the hold begins.

// File: rtl/strm_pkt_pkg.sv
package strm_pkt_pkg;

  // width of a one-based count that must reach n
  function automatic int unsigned count_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // FIFO entries needed: every in-flight word plus the one being handed over
  function automatic int unsigned fifo_depth(input int unsigned lat);
    return lat + 1;
  endfunction

  function automatic bit first_of_packet(input int unsigned cnt);
    return cnt == 1;
  endfunction

  function automatic bit last_of_packet(input int unsigned cnt, input int unsigned len);
    return cnt == len;
  endfunction

  // circular pointer advance
  function automatic int unsigned ptr_next(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // words that stay committed once the current pop completes
  function automatic int unsigned committed_after_pop(input int unsigned fill,
                                                      input int unsigned inflight,
                                                      input bit pop);
    return fill + inflight - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/strm_pkt_framer.sv
module strm_pkt_framer
  import strm_pkt_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PKT_LEN = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  output logic              push,
  output logic [DATA_W+1:0] word
);

  logic mark_first;
  logic mark_last;

  generate
    if (PKT_LEN == 1) begin : g_single
      // every word is a whole packet; the count carries no information
      logic unused_cnt;
      assign unused_cnt = ^in_count;
      assign mark_first = 1'b1 | unused_cnt;
      assign mark_last  = 1'b1;
    end else begin : g_multi
      assign mark_first = first_of_packet(int'(in_count));
      assign mark_last  = last_of_packet(int'(in_count), PKT_LEN);
    end
  endgenerate

  assign push = in_valid;
  assign word = {mark_first, mark_last, in_data};

endmodule

// File: rtl/strm_pkt_fifo.sv
module strm_pkt_fifo
  import strm_pkt_pkg::*;
#(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] rdata,
  output logic [FILL_W-1:0] fill,
  output logic              empty,
  output logic              full
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic              do_pop;

  assign empty  = (fill == '0);
  assign full   = (fill == FILL_W'(DEPTH));
  assign do_pop = pop && !empty;
  assign rdata  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push)   wr_ptr <= PTR_W'(ptr_next(int'(wr_ptr), DEPTH));
      if (do_pop) rd_ptr <= PTR_W'(ptr_next(int'(rd_ptr), DEPTH));
      case ({push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R7: a word must never be written into a full FIFO without a pop
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (push && !do_pop) |-> !full);

  // R7: occupancy stays within the storage
  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(DEPTH));

endmodule

// File: rtl/strm_pkt_credit.sv
module strm_pkt_credit
  import strm_pkt_pkg::*;
#(
  parameter int unsigned PIPE_LAT = 3,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned FILL_W   = 3,
  localparam int unsigned INF_W   = $clog2(PIPE_LAT + 1),
  localparam int unsigned SUM_W   = $clog2(DEPTH + PIPE_LAT + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              out_ready,
  input  logic              pop,
  input  logic [FILL_W-1:0] fill,
  output logic              dp_enable,
  output logic [INF_W-1:0]  inflight
);

  logic [PIPE_LAT-1:0] en_hist;
  logic [SUM_W-1:0]    committed;
  logic                room;

  // one history bit per pipeline stage: the oldest bit marks the word arriving now
  generate
    if (PIPE_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) en_hist <= '0;
        else     en_hist <= dp_enable;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) en_hist <= '0;
        else     en_hist <= {en_hist[PIPE_LAT-2:0], dp_enable};
      end
    end
  endgenerate

  always_comb begin
    inflight = '0;
    for (int i = 0; i < PIPE_LAT; i++) begin
      inflight = inflight + INF_W'(en_hist[i]);
    end
  end

  assign committed = SUM_W'(committed_after_pop(int'(fill), int'(inflight), pop));
  assign room      = (committed < SUM_W'(DEPTH));
  assign dp_enable = !rst && out_ready && room;

  // R6: an idle block with a ready sink enables the datapath at once
  assert_instant_enable_R6: assert property (@(posedge clk) disable iff (rst)
    (out_ready && fill == '0 && inflight == '0) |-> dp_enable);

  // R7: the in-flight count never exceeds the pipeline length
  assert_inflight_bound_R7: assert property (@(posedge clk) disable iff (rst)
    inflight <= INF_W'(PIPE_LAT));

endmodule

// File: rtl/strm_pkt_source.sv
module strm_pkt_source
  import strm_pkt_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PKT_LEN  = 4,
  parameter int unsigned PIPE_LAT = 3,
  localparam int unsigned CNT_W   = count_width(PKT_LEN),
  localparam int unsigned DEPTH   = fifo_depth(PIPE_LAT),
  localparam int unsigned WORD_W  = DATA_W + 2,
  localparam int unsigned FILL_W  = $clog2(DEPTH + 1),
  localparam int unsigned INF_W   = $clog2(PIPE_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  output logic              dp_enable,
  output logic              stall,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  // named internal events, visible to the assertions
  logic              push_ev;
  logic              pop_ev;
  logic [WORD_W-1:0] push_word;
  logic [WORD_W-1:0] head_word;
  logic [FILL_W-1:0] fill;
  logic [INF_W-1:0]  inflight;
  logic              fifo_empty;
  logic              fifo_full;

  strm_pkt_framer #(
    .DATA_W (DATA_W),
    .PKT_LEN(PKT_LEN),
    .CNT_W  (CNT_W)
  ) framer_i (
    .in_valid(in_valid),
    .in_data (in_data),
    .in_count(in_count),
    .push    (push_ev),
    .word    (push_word)
  );

  strm_pkt_fifo #(
    .WORD_W(WORD_W),
    .DEPTH (DEPTH)
  ) fifo_i (
    .clk  (clk),
    .rst  (rst),
    .push (push_ev),
    .wdata(push_word),
    .pop  (pop_ev),
    .rdata(head_word),
    .fill (fill),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  strm_pkt_credit #(
    .PIPE_LAT(PIPE_LAT),
    .DEPTH   (DEPTH),
    .FILL_W  (FILL_W)
  ) credit_i (
    .clk      (clk),
    .rst      (rst),
    .out_ready(out_ready),
    .pop      (pop_ev),
    .fill     (fill),
    .dp_enable(dp_enable),
    .inflight (inflight)
  );

  assign out_valid = !fifo_empty;
  assign pop_ev    = out_valid && out_ready;
  assign out_sop   = head_word[WORD_W-1];
  assign out_eop   = head_word[WORD_W-2];
  assign out_data  = head_word[DATA_W-1:0];
  assign stall     = !out_ready;

  // R5: a refusing sink halts the datapath and is reported as a stall
  assert_stall_halts_R5: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> (!dp_enable && stall));

  // R8: an offered word is held until taken
  assert_hold_word_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sop) && $stable(out_eop)));

  // R7: a full FIFO with the sink blocked cannot also be fed by the datapath
  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !out_ready) |-> !dp_enable);

  // R10: a word pushed into an empty FIFO is offered on the next cycle
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    (push_ev && fifo_empty) |=> out_valid);

endmodule

// File: tb/strm_pkt_source_tb.sv
module strm_pkt_source_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned PKT_LEN    = 4;
  localparam int unsigned PIPE_LAT   = 3;
  localparam int unsigned CNT_W      = $clog2(PKT_LEN + 1);
  localparam int unsigned DEPTH      = PIPE_LAT + 1;
  localparam int unsigned WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst;
  logic out_ready;
  logic src_on;
  logic chk_en;

  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic [CNT_W-1:0]  in_count;
  logic              dp_enable, stall, out_valid, out_sop, out_eop;
  logic [DATA_W-1:0] out_data;

  logic              s_enable, s_stall, s_valid, s_sop, s_eop;
  logic [DATA_W-1:0] s_data;

  int checks = 0;
  int errors = 0;
  int unsigned produced;
  int unsigned received = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // datapath model: a word enabled now arrives PIPE_LAT clocks later
  logic [PIPE_LAT-1:0] pv;
  logic [DATA_W-1:0]   pd [PIPE_LAT];
  logic [CNT_W-1:0]    pc [PIPE_LAT];

  always @(posedge clk) begin
    if (rst) begin
      pv       <= '0;
      produced <= 0;
    end else begin
      for (int k = PIPE_LAT - 1; k > 0; k--) begin
        pv[k] <= pv[k-1];
        pd[k] <= pd[k-1];
        pc[k] <= pc[k-1];
      end
      pv[0] <= dp_enable && src_on;
      pd[0] <= DATA_W'(produced);
      pc[0] <= CNT_W'(produced % PKT_LEN + 1);
      if (dp_enable && src_on) produced <= produced + 1;
    end
  end

  assign in_valid = pv[PIPE_LAT-1];
  assign in_data  = pd[PIPE_LAT-1];
  assign in_count = pc[PIPE_LAT-1];

  strm_pkt_source #(
    .DATA_W  (DATA_W),
    .PKT_LEN (PKT_LEN),
    .PIPE_LAT(PIPE_LAT)
  ) dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_count(in_count),
    .dp_enable(dp_enable), .stall(stall),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  // single-word packets, always-ready sink; count bit varies and must not matter
  strm_pkt_source #(
    .DATA_W  (DATA_W),
    .PKT_LEN (1),
    .PIPE_LAT(PIPE_LAT)
  ) dut_single_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_count(in_count[0]),
    .dp_enable(s_enable), .stall(s_stall),
    .out_valid(s_valid), .out_ready(1'b1),
    .out_data(s_data), .out_sop(s_sop), .out_eop(s_eop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  logic              hold_pending = 1'b0;
  logic [DATA_W-1:0] held_data;
  logic              held_sop, held_eop;
  logic              prev_in_valid = 1'b0;
  logic [DATA_W-1:0] prev_in_data = '0;

  task automatic cycle(input logic r);
    int unsigned k;
    int unsigned outstanding;
    bit exp_en;
    @(negedge clk);
    out_ready = r;
    #1;
    outstanding = produced - received;
    if (!r) begin
      check(dp_enable == 1'b0, "R5 enable", int'(dp_enable), 0);
      check(stall == 1'b1, "R5 stall", int'(stall), 1);
    end else if (chk_en) begin
      exp_en = (outstanding - (out_valid ? 1 : 0)) < DEPTH;
      check(dp_enable == exp_en, "R6 enable", int'(dp_enable), int'(exp_en));
    end
    if (chk_en) check(outstanding <= DEPTH, "R7 committed", int'(outstanding), DEPTH);
    if (hold_pending) begin
      check(out_valid == 1'b1, "R8 valid", int'(out_valid), 1);
      check(out_data == held_data && out_sop == held_sop && out_eop == held_eop,
            "R8 word", int'({out_sop, out_eop, out_data}), int'({held_sop, held_eop, held_data}));
    end
    if (out_valid && r) begin
      k = received % PKT_LEN + 1;
      check(out_data == DATA_W'(received), "R7 order", int'(out_data), int'(DATA_W'(received)));
      if (k == 1)
        check(out_sop == 1'b1 && out_eop == 1'b0, "R1 first mark",
              int'({out_sop, out_eop}), 2);
      else if (k == PKT_LEN)
        check(out_sop == 1'b0 && out_eop == 1'b1, "R2 last mark",
              int'({out_sop, out_eop}), 1);
      else
        check(out_sop == 1'b0 && out_eop == 1'b0, "R3 middle mark",
              int'({out_sop, out_eop}), 0);
      received++;
    end
    hold_pending = out_valid && !r;
    held_data = out_data;
    held_sop  = out_sop;
    held_eop  = out_eop;
    // single-word packet instance
    check(s_valid == prev_in_valid, "R10 latency", int'(s_valid), int'(prev_in_valid));
    if (s_valid) begin
      check(s_sop && s_eop, "R4 marks", int'({s_sop, s_eop}), 3);
      check(s_data == prev_in_data, "R10 data", int'(s_data), int'(prev_in_data));
    end
    prev_in_valid = in_valid;
    prev_in_data  = in_data;
  endtask

  initial begin
    logic [7:0] lfsr;
    rst = 1'b1;
    out_ready = 1'b1;
    src_on = 1'b1;
    chk_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R9 valid in reset", int'(out_valid), 0);
      check(dp_enable == 1'b0, "R9 enable in reset", int'(dp_enable), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9 valid after reset", int'(out_valid), 0);
    check(dp_enable == 1'b1, "R9 enable after reset", int'(dp_enable), 1);

    repeat (40) cycle(1'b1);
    for (int i = 0; i < 40; i++) cycle(1'(i % 2));
    for (int j = 0; j < 3; j++) begin
      repeat (12) cycle(1'b0);
      repeat (12) cycle(1'b1);
    end
    for (int i = 0; i < 45; i++) cycle(i % 3 == 0);
    lfsr = 8'hA5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cycle(lfsr[0] | lfsr[3]);
    end

    // drain with the source switched off
    src_on = 1'b0;
    cycle(1'b1);
    chk_en = 1'b0;
    repeat (PIPE_LAT + DEPTH + 4) cycle(1'b1);
    check(received == produced, "R7 all delivered", int'(received), int'(produced));

    // reset with words held in the FIFO
    src_on = 1'b1;
    repeat (6) cycle(1'b1);
    repeat (8) cycle(1'b0);
    check(out_valid == 1'b1, "R9 FIFO holds words", int'(out_valid), 1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 reset empties", int'(out_valid), 0);
    out_ready = 1'b1;
    rst = 1'b0;
    #1;
    check(dp_enable == 1'b1, "R9 enable back", int'(dp_enable), 1);
    check(out_valid == 1'b0, "R9 still empty", int'(out_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule